// File: doc/BRIEF.md
# Dual-Mode Time-Slot Interchanger

This block moves byte samples between the slots of one frame-based highway. A free-running slot counter marks the current slot. The sample on `din` belongs to input slot `slot_no`, and `dout` carries the sample for output slot `slot_no` in the same cycle. A speech store keeps one byte per slot. A control store keeps one word per slot, made of a valid flag and a slot number.

The `mode` input selects how the control store steers the speech store.

- **Output-steered (`mode`=0):** every input sample is stored at its own slot number. Each output slot reads the location named by its control word.
- **Input-steered (`mode`=1):** each input sample is stored at the location named by its control word. Each output slot reads its own location, and that location is then emptied.

A controller programs or removes one connection per cycle through the `cfg_*` port.

Top module: `slot_interchanger`

## Requirements
- R1: While `rst_n` is low the slot counter holds 0 and every control word is invalid. Right after release `slot_no` is 0 and `dout` is 0.
- R2: `slot_no` advances by one each cycle from 0 up to SLOTS-1 and then returns to 0.
- R3: In output-steered mode (`mode`=0), the input sample of slot k is stored at speech location k. In output slot j with a valid control word holding k, `dout` is the content of location k.
- R4: In output-steered mode, an output slot whose control word is invalid drives `dout` = 0.
- R5: In input-steered mode (`mode`=1), the input sample of slot k is stored at the location held by control word k. If that word is invalid, the sample is stored nowhere.
- R6: In input-steered mode, output slot j reads location j and then empties it. An output slot that no input slot targets therefore reads 0.
- R7: A `cfg_we` pulse writes {`cfg_valid`, `cfg_target`} into control word `cfg_slot`, and the new word steers from the next cycle on. To connect input slot 4 to output slot 6, mode 0 writes target 4 into word 6 and mode 1 writes target 6 into word 4.
- R8: A connection from input slot k to output slot j delivers the sample j-k slots later when j>k. When j<=k, the sample appears in output slot j of the following frame, SLOTS-k+j slots later.
- R9: Writing an invalid word stops the connection. In input-steered mode, a sample already stored for that connection is also emptied and never appears.
- R10: When one location is written and read in the same slot, the read returns the sample stored before that slot.
- R11: All SLOTS connections of any full permutation can be active at once, and each carries its own samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | 0 = output-steered, 1 = input-steered |
| din | input | DW | Sample of input slot `slot_no` |
| cfg_we | input | 1 | Control word write strobe |
| cfg_slot | input | SW | Control word index |
| cfg_target | input | SW | Slot number stored in the word |
| cfg_valid | input | 1 | Valid flag stored in the word; 0 disconnects |
| slot_no | output | SW | Current slot |
| dout | output | DW | Sample of output slot `slot_no` |

## Verification
The sample write and the sample read can fall on the same speech location in one slot. This happens whenever a connection joins input slot k to output slot k, in either mode. The bench drives such connections and expects the sample of the previous frame, never the one arriving in that slot.

In input-steered mode, the read-empty and a disconnect-empty can also meet a pending sample. A connection whose output slot comes before its input slot is removed between the write and the read, and that output slot must then read zero in the next frame.

// File: rtl/tsi_pkg.sv
`timescale 1ns/1ps
package tsi_pkg;
  typedef enum logic {TSI_OUT_CTRL = 1'b0, TSI_IN_CTRL = 1'b1} tsi_mode_e;

  // location written by the sample of the current slot
  function automatic int tsi_write_loc(logic in_ctrl, int slot, int tgt);
    return in_ctrl ? tgt : slot;
  endfunction

  // location read for the output of the current slot
  function automatic int tsi_read_loc(logic in_ctrl, int slot, int tgt);
    return in_ctrl ? slot : tgt;
  endfunction

  function automatic int tsi_next_slot(int s, int n);
    return (s == n - 1) ? 0 : s + 1;
  endfunction
endpackage

// File: rtl/tsi_slot_ctr.sv
`timescale 1ns/1ps
module tsi_slot_ctr #(
  parameter int SLOTS = 32,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] slot
);
  import tsi_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= '0;
    else        slot <= SW'(tsi_next_slot(int'(slot), SLOTS));
  end
endmodule

// File: rtl/tsi_ctrl_mem.sv
`timescale 1ns/1ps
module tsi_ctrl_mem #(
  parameter int SLOTS = 32,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_idx,
  input  logic          wr_valid,
  input  logic [SW-1:0] wr_target,
  input  logic [SW-1:0] rd_idx,
  output logic          rd_valid,
  output logic [SW-1:0] rd_target,
  output logic          old_valid,
  output logic [SW-1:0] old_target
);
  logic          vld [SLOTS];
  logic [SW-1:0] tgt [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        vld[i] <= 1'b0;
        tgt[i] <= '0;
      end
    end else if (wr_en) begin
      vld[wr_idx] <= wr_valid;
      tgt[wr_idx] <= wr_target;
    end
  end

  assign rd_valid   = vld[rd_idx];
  assign rd_target  = tgt[rd_idx];
  assign old_valid  = vld[wr_idx];
  assign old_target = tgt[wr_idx];
endmodule

// File: rtl/tsi_speech_mem.sv
`timescale 1ns/1ps
module tsi_speech_mem #(
  parameter int SLOTS = 32,
  parameter int DW = 8,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          clr_a_en,
  input  logic [SW-1:0] clr_a,
  input  logic          clr_b_en,
  input  logic [SW-1:0] clr_b,
  input  logic [SW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [SLOTS];

  // a write beats an empty request on the same location
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (we && waddr == SW'(i))
          mem[i] <= wdata;
        else if ((clr_a_en && clr_a == SW'(i)) || (clr_b_en && clr_b == SW'(i)))
          mem[i] <= '0;
      end
    end
  end

  // read sees the content stored before this edge
  assign rdata = mem[raddr];
endmodule

// File: rtl/slot_interchanger.sv
`timescale 1ns/1ps
module slot_interchanger #(
  parameter int SLOTS = 32,
  parameter int DW = 8,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic [DW-1:0] din,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_slot,
  input  logic [SW-1:0] cfg_target,
  input  logic          cfg_valid,
  output logic [SW-1:0] slot_no,
  output logic [DW-1:0] dout
);
  import tsi_pkg::*;

  tsi_mode_e     mode_e;
  logic          mode_in;
  logic [SW-1:0] slot;
  logic          ctl_vld;
  logic [SW-1:0] ctl_tgt;
  logic          old_vld;
  logic [SW-1:0] old_tgt;
  logic          sm_we;
  logic [SW-1:0] sm_waddr;
  logic [SW-1:0] sm_raddr;
  logic [DW-1:0] sm_rdata;
  logic          rd_idle;
  logic          clr_rd_en;
  logic          clr_disc_en;
  logic          sm_col;

  assign mode_e  = tsi_mode_e'(mode);
  assign mode_in = (mode_e == TSI_IN_CTRL);

  tsi_slot_ctr #(.SLOTS(SLOTS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .slot(slot)
  );

  tsi_ctrl_mem #(.SLOTS(SLOTS)) u_cm (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_slot), .wr_valid(cfg_valid), .wr_target(cfg_target),
    .rd_idx(slot), .rd_valid(ctl_vld), .rd_target(ctl_tgt),
    .old_valid(old_vld), .old_target(old_tgt)
  );

  // steering of the speech store
  assign sm_we    = mode_in ? ctl_vld : 1'b1;
  assign sm_waddr = SW'(tsi_write_loc(mode_in, int'(slot), int'(ctl_tgt)));
  assign sm_raddr = SW'(tsi_read_loc(mode_in, int'(slot), int'(ctl_tgt)));
  assign sm_col   = sm_we && (sm_waddr == sm_raddr);

  // input-steered: empty a location once it is read, and the old target when its connection changes
  assign clr_rd_en   = mode_in;
  assign clr_disc_en = mode_in && cfg_we && old_vld && (!cfg_valid || cfg_target != old_tgt);

  tsi_speech_mem #(.SLOTS(SLOTS), .DW(DW)) u_sm (
    .clk(clk), .rst_n(rst_n),
    .we(sm_we), .waddr(sm_waddr), .wdata(din),
    .clr_a_en(clr_rd_en), .clr_a(slot),
    .clr_b_en(clr_disc_en), .clr_b(old_tgt),
    .raddr(sm_raddr), .rdata(sm_rdata)
  );

  assign rd_idle = !mode_in && !ctl_vld;
  assign dout    = rd_idle ? '0 : sm_rdata;
  assign slot_no = slot;
endmodule

// File: rtl/slot_interchanger_chk.sv
`timescale 1ns/1ps
module slot_interchanger_chk #(
  parameter int SLOTS = 32,
  parameter int DW = 8,
  localparam int SW = $clog2(SLOTS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode,
  input logic [SW-1:0] slot,
  input logic [DW-1:0] dout,
  input logic          sm_we,
  input logic [SW-1:0] sm_waddr,
  input logic [SW-1:0] sm_raddr,
  input logic          ctl_vld
);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  a_r1_reset_slot: assert property (@(posedge clk) !rst_n |=> slot == '0);

  a_r2_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    slot == LAST |=> slot == '0);

  a_r2_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    slot != LAST |=> slot == $past(slot) + 1'b1);

  a_r3_seq_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |-> sm_we && sm_waddr == slot);

  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mode && !ctl_vld |-> dout == '0);

  a_r5_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    mode && !ctl_vld |-> !sm_we);

  a_r6_seq_read: assert property (@(posedge clk) disable iff (!rst_n)
    mode |-> sm_raddr == slot);
endmodule

bind slot_interchanger slot_interchanger_chk #(.SLOTS(SLOTS), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .slot(slot), .dout(dout),
  .sm_we(sm_we), .sm_waddr(sm_waddr), .sm_raddr(sm_raddr), .ctl_vld(ctl_vld)
);

// File: tb/slot_interchanger_bench.sv
`timescale 1ns/1ps
module slot_interchanger_bench;
  localparam int SLOTS = 32;
  localparam int DW = 8;
  localparam int SW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode = 1'b0;
  logic [DW-1:0] din = '0;
  logic          cfg_we = 1'b0;
  logic [SW-1:0] cfg_slot = '0;
  logic [SW-1:0] cfg_target = '0;
  logic          cfg_valid = 1'b0;
  logic [SW-1:0] slot_no;
  logic [DW-1:0] dout;

  slot_interchanger #(.SLOTS(SLOTS), .DW(DW)) u_slot_interchanger (
    .clk(clk), .rst_n(rst_n), .mode(mode), .din(din),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_target(cfg_target), .cfg_valid(cfg_valid),
    .slot_no(slot_no), .dout(dout)
  );

  always #4 clk = ~clk;

  int    checks = 0;
  int    failures = 0;
  int    fr = 0;
  int    exp_slot = 0;
  bit    chk_en = 0;
  string tag = "R3";
  int    src_of [SLOTS];
  bit    pend = 0;
  int    p_idx, p_tgt;
  bit    p_vld;

  // {mode, input slot, output slot}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 5'd4,  5'd6},  {1'b0, 5'd6,  5'd4},  {1'b0, 5'd9, 5'd9},  {1'b0, 5'd0, 5'd31},
    {1'b1, 5'd4,  5'd6},  {1'b1, 5'd6,  5'd4},  {1'b1, 5'd9, 5'd9},  {1'b1, 5'd31, 5'd0}
  };

  function automatic logic [DW-1:0] samp(int f, int s);
    return DW'(((f * 37 + s * 11) % 255) + 1);
  endfunction

  function automatic int expv(int j);
    int k = src_of[j];
    if (k < 0) return 0;
    return (j > k) ? int'(samp(fr, k)) : int'(samp(fr - 1, k));
  endfunction

  task automatic check(string t, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s slot=%0d got=%0h exp=%0h", t, exp_slot, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check("R2", int'(slot_no), exp_slot);
    if (chk_en) check(tag, int'(dout), expv(int'(slot_no)));
    din = samp(fr, int'(slot_no));
    cfg_we = 1'b0;
    if (pend) begin
      cfg_we = 1'b1; cfg_slot = SW'(p_idx); cfg_target = SW'(p_tgt); cfg_valid = p_vld;
      pend = 0;
      if (!mode) src_of[p_idx] = p_vld ? p_tgt : -1;
      else begin
        for (int x = 0; x < SLOTS; x++) if (src_of[x] == p_idx) src_of[x] = -1;
        if (p_vld) src_of[p_tgt] = p_idx;
      end
    end
    if (exp_slot == SLOTS - 1) fr++;
    exp_slot = (exp_slot + 1) % SLOTS;
  endtask

  task automatic prog(int idx, int tgt, bit vld);
    pend = 1; p_idx = idx; p_tgt = tgt; p_vld = vld;
    tick();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_reset(bit m);
    @(negedge clk);
    rst_n = 1'b0; mode = m; cfg_we = 1'b0; chk_en = 0;
    for (int x = 0; x < SLOTS; x++) src_of[x] = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", int'(slot_no), 0);
    check("R1", int'(dout), 0);
    fr = 0;
    din = samp(0, 0);
    exp_slot = 1;
  endtask

  // connect input k to output j in the current mode
  task automatic connect(int k, int j);
    if (!mode) prog(j, k, 1'b1);
    else       prog(k, j, 1'b1);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // table walk: single connections in both modes (R3 R4 R5 R6 R8 R10)
    for (int v = 0; v < 8; v++) begin
      do_reset(VEC[v][10]);
      connect(int'(VEC[v][9:5]), int'(VEC[v][4:0]));
      run(2 * SLOTS);
      if (VEC[v][9:5] == VEC[v][4:0]) tag = "R10";
      else if (!VEC[v][10]) tag = "R3 R4 R8";
      else tag = "R5 R6 R8";
      chk_en = 1;
      run(2 * SLOTS);
      chk_en = 0;
    end

    // full permutation in both modes (R11)
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      for (int j = 0; j < SLOTS; j++) connect((j * 5 + 3) % SLOTS, j);
      run(2 * SLOTS);
      tag = "R11"; chk_en = 1;
      run(2 * SLOTS);
      chk_en = 0;
    end

    // output-steered: connection takes effect next cycle (R7), disconnect (R9)
    do_reset(1'b0);
    run(SLOTS);
    tag = "R7"; chk_en = 1;
    while (exp_slot != 5) tick();
    connect(4, 6);
    run(SLOTS);
    tag = "R9";
    while (exp_slot != 2) tick();
    prog(6, 0, 1'b0);
    run(SLOTS);
    chk_en = 0;

    // input-steered: pending sample is dropped on disconnect (R9)
    do_reset(1'b1);
    connect(20, 5);
    run(2 * SLOTS);
    tag = "R9"; chk_en = 1;
    run(SLOTS);
    while (exp_slot != 25) tick();
    prog(20, 0, 1'b0);
    run(2 * SLOTS);
    chk_en = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule